// File: doc/BRIEF.md
# CAN bit-timing prescaler and segmenter

This block turns the system clock into CAN time quanta and places the segments of every bit on that quantum grid. A 10-bit prescaler sets the quantum length. Its low six bits sit in a timing word, and its high four bits sit in a separate extension word. The timing word also holds the length of the segment before the sample point, the length of the segment after it, and the resynchronisation jump width. Every field is stored as its value minus one.

Each bit is a single synchronisation quantum, then segment 1, then segment 2. The block reports three single-cycle strobes: the quantum tick, the sample point at the end of segment 1, and the bit boundary at the end of segment 2. Configuration can be written only while the controller is held in initialisation with configuration change enabled. While initialisation is held, timing stops.

A falling edge on the receive line while the bus is idle hard-synchronises the bit. A falling edge during a frame resynchronises the bit, bounded by the jump width.

The segment sequencer has four states:
- `BT_HALT`: held while `ctrl_init` is high. It moves to `BT_SYNC` once init is released.
- `BT_SYNC`: the one-quantum sync segment. It moves to `BT_SEG1` on a tick.
- `BT_SEG1`: segment 1. It moves to `BT_SEG2` on the tick that ends the segment, and that tick is the sample strobe.
- `BT_SEG2`: segment 2. It moves to `BT_SYNC` on the tick that ends the segment, and that tick is the bit strobe.

A hard sync forces `BT_SYNC` from any running state. Init forces `BT_HALT` from any state.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, and on every cycle after a clock edge at which `ctrl_init` is high, `tq_tick`, `sample_strobe` and `bit_end_strobe` are all low.
- R2: A write lands only when `cfg_wr`, `ctrl_init` and `ctrl_cce` are all high at the clock edge. With `cfg_sel`=0 it writes the timing word: prescaler low bits in [5:0], jump-width-minus-one in [7:6], segment-1-minus-one in [11:8], segment-2-minus-one in [14:12]. With `cfg_sel`=1 it writes the extension word, whose bits [3:0] are prescaler bits [9:6].
- R3: While running, `tq_tick` pulses once every P+1 clocks, where P is the 10-bit prescaler field. This gives a division of up to 1024.
- R4: When init is released at clock edge E0, the sync quantum starts at E0. A bit lasts 1+(T1+1)+(T2+1) quanta. `sample_strobe` coincides with the tick that ends segment 1, and `bit_end_strobe` coincides with the tick that ends segment 2.
- R5: A write attempted without both `ctrl_init` and `ctrl_cce` high changes neither word. The earlier timing stays in force.
- R6: With `bus_idle` high, a falling edge on `rx_line` (seen two clocks later through the input register pair) restarts the bit at the sync segment and clears the prescaler.
- R7: With `bus_idle` low, a falling edge seen during segment 1 lengthens segment 1 by the number of segment-1 quanta elapsed, counting the current one, capped at jump-width-minus-one plus one.
- R8: With `bus_idle` low, a falling edge seen during segment 2 shortens segment 2 by up to jump-width-minus-one plus one quanta. The segment never ends before the quantum in progress.
- R9: A falling edge seen in the sync segment, a second falling edge within the same bit, and any rising edge leave the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the timing word, 1 selects the extension word |
| cfg_wdata | input | 16 | Write data |
| ctrl_init | input | 1 | Initialisation hold; stops timing and permits writes |
| ctrl_cce | input | 1 | Configuration change enable |
| rx_line | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | High selects hard sync; low selects resynchronisation |
| tq_tick | output | 1 | Last clock of each time quantum |
| sample_strobe | output | 1 | Sample point strobe |
| bit_end_strobe | output | 1 | Bit boundary strobe |

## Verification
The hardest cases to reach from the ports are a receive edge landing in one chosen quantum of a chosen segment, and a second edge arriving inside the same bit. Each needs cycle-exact placement through the two-flop input path. The bench counts clocks from the edge that releases init. It drives `rx_line` low one clock before the target quantum, at an offset where the prescaler count is zero, so no quantum tick falls on the same edge. It then predicts the sample and bit-end cycles from the clamped extension or shortening.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int BRP_LO_W = 6;
    localparam int BRP_HI_W = 4;
    localparam int BRP_W    = BRP_LO_W + BRP_HI_W;
    localparam int SJW_W    = 2;
    localparam int TS1_W    = 4;
    localparam int TS2_W    = 3;

    localparam int SJW_LSB  = BRP_LO_W;
    localparam int TS1_LSB  = SJW_LSB + SJW_W;
    localparam int TS2_LSB  = TS1_LSB + TS1_W;
    localparam int TIM_W    = TS2_LSB + TS2_W;

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic [TS1_W-1:0] ts1;
        logic [TS2_W-1:0] ts2;
    } bt_cfg_t;

    typedef enum logic [1:0] {
        BT_HALT = 2'd0,
        BT_SYNC = 2'd1,
        BT_SEG1 = 2'd2,
        BT_SEG2 = 2'd3
    } bt_state_e;

endpackage

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
    import can_bt_pkg::*;
#(
    parameter int DATA_W = 16
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              init_i,
    input  logic              cce_i,
    output bt_cfg_t           cfg_o
);
    localparam logic [TIM_W-1:0] TIM_RST = TIM_W'(1) << TS1_LSB;

    logic [TIM_W-1:0]    timing_q;
    logic [BRP_HI_W-1:0] ext_q;
    logic                wr_ok;
    logic                unused_hi;

    assign wr_ok     = wr_i && init_i && cce_i;
    assign unused_hi = ^data_i[DATA_W-1:TIM_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing_q <= TIM_RST;
            ext_q    <= '0;
        end else if (wr_ok) begin
            if (sel_i) begin
                ext_q <= data_i[BRP_HI_W-1:0];
            end else begin
                timing_q <= data_i[TIM_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_o.brp = {ext_q, timing_q[BRP_LO_W-1:0]};
        cfg_o.sjw = timing_q[SJW_LSB +: SJW_W];
        cfg_o.ts1 = timing_q[TS1_LSB +: TS1_W];
        cfg_o.ts2 = timing_q[TS2_LSB +: TS2_W];
    end

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && init_i && cce_i) |=> ($stable(timing_q) && $stable(ext_q)));

    // R2
    cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && init_i && cce_i && !sel_i) |=> (timing_q == $past(data_i[TIM_W-1:0])));

endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int CNT_W = 10
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] div_m1_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] pcnt_q;

    assign tick_o = run_i && (pcnt_q >= div_m1_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run_i || restart_i || tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + CNT_W'(1);
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart_i && (div_m1_i != '0)) |=> !tick_o);

endmodule

// File: rtl/bt_seg_fsm.sv
module bt_seg_fsm
    import can_bt_pkg::*;
#(
    parameter int Q_W = TS1_W + 2
)
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_i,
    input  logic      tick_i,
    input  logic      fall_i,
    input  logic      idle_i,
    input  bt_cfg_t   cfg_i,
    output bt_state_e state_o,
    output logic      sample_o,
    output logic      bit_end_o,
    output logic      restart_o
);
    localparam logic [Q_W-1:0] ONE = Q_W'(1);

    bt_state_e      state_q, state_d;
    logic [Q_W-1:0] qcnt_q, t1_q, t2_q;
    logic           adj_q;
    logic [Q_W-1:0] s1_len, s2_len, sjw_len, elapsed, ext, floor2, t1_now, t2_now;
    logic           hsync, rsync, in_seg, seg1_done, seg2_done;

    always_comb begin
        s1_len    = Q_W'(cfg_i.ts1) + ONE;
        s2_len    = Q_W'(cfg_i.ts2) + ONE;
        sjw_len   = Q_W'(cfg_i.sjw) + ONE;
        elapsed   = qcnt_q + ONE;
        ext       = (elapsed < sjw_len) ? elapsed : sjw_len;
        floor2    = (s2_len > sjw_len) ? (s2_len - sjw_len) : '0;
        in_seg    = (state_q == BT_SEG1) || (state_q == BT_SEG2);
        hsync     = fall_i && idle_i && !halt_i && (state_q != BT_HALT);
        rsync     = fall_i && !idle_i && in_seg && !adj_q;
        t1_now    = (rsync && state_q == BT_SEG1) ? (t1_q + ext) : t1_q;
        t2_now    = (rsync && state_q == BT_SEG2) ?
                    ((elapsed > floor2) ? elapsed : floor2) : t2_q;
        seg1_done = tick_i && !hsync && (state_q == BT_SEG1) && (qcnt_q == t1_now - ONE);
        seg2_done = tick_i && !hsync && (state_q == BT_SEG2) && (qcnt_q >= t2_now - ONE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_HALT: state_d = BT_SYNC;
            BT_SYNC: if (tick_i)    state_d = BT_SEG1;
            BT_SEG1: if (seg1_done) state_d = BT_SEG2;
            BT_SEG2: if (seg2_done) state_d = BT_SYNC;
            default: state_d = BT_HALT;
        endcase
        if (hsync)  state_d = BT_SYNC;
        if (halt_i) state_d = BT_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BT_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt_q <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
            adj_q  <= 1'b0;
        end else begin
            if (!in_seg || hsync || (state_d != state_q)) begin
                qcnt_q <= '0;
            end else if (tick_i) begin
                qcnt_q <= qcnt_q + ONE;
            end
            if (!in_seg || hsync) begin
                t1_q  <= s1_len;
                t2_q  <= s2_len;
                adj_q <= 1'b0;
            end else if (rsync) begin
                t1_q  <= t1_now;
                t2_q  <= t2_now;
                adj_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_o   = state_q;
        sample_o  = seg1_done;
        bit_end_o = seg2_done;
        restart_o = hsync;
    end

    // R4
    sample_to_seg2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !halt_i) |=> (state_q == BT_SEG2));

    // R4
    bit_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end_o && !halt_i) |=> (state_q == BT_SYNC));

    // R6
    hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> ((state_q == BT_SYNC) && (qcnt_q == '0)));

    // R7
    seg1_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BT_SEG1) |-> (t1_q <= s1_len + sjw_len));

    // R8
    seg2_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BT_SEG2) |-> ((t2_q >= ONE) && (t2_q <= s2_len)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int DATA_W = 16
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ctrl_init,
    input  logic              ctrl_cce,
    input  logic              rx_line,
    input  logic              bus_idle,
    output logic              tq_tick,
    output logic              sample_strobe,
    output logic              bit_end_strobe
);
    bt_cfg_t   cfg;
    bt_state_e state;
    logic      rx_d1, rx_d2, rx_fall, restart, run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_d1 <= 1'b1;
            rx_d2 <= 1'b1;
        end else begin
            rx_d1 <= rx_line;
            rx_d2 <= rx_d1;
        end
    end

    assign rx_fall = rx_d2 && !rx_d1;
    assign run     = (state != BT_HALT);

    bt_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr),
        .sel_i  (cfg_sel),
        .data_i (cfg_wdata),
        .init_i (ctrl_init),
        .cce_i  (ctrl_cce),
        .cfg_o  (cfg)
    );

    bt_prescaler #(.CNT_W(BRP_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .div_m1_i  (cfg.brp),
        .tick_o    (tq_tick)
    );

    bt_seg_fsm #(.Q_W(TS1_W + 2)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (ctrl_init),
        .tick_i    (tq_tick),
        .fall_i    (rx_fall),
        .idle_i    (bus_idle),
        .cfg_i     (cfg),
        .state_o   (state),
        .sample_o  (sample_strobe),
        .bit_end_o (bit_end_strobe),
        .restart_o (restart)
    );

    // R1
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_init |=> (!tq_tick && !sample_strobe && !bit_end_strobe));

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ctrl_init = 1'b1;
    logic        ctrl_cce = 1'b1;
    logic        rx_line = 1'b1;
    logic        bus_idle = 1'b0;
    logic        tq_tick, sample_strobe, bit_end_strobe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;
    ev_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl_init(ctrl_init), .ctrl_cce(ctrl_cce),
        .rx_line(rx_line), .bus_idle(bus_idle), .tq_tick(tq_tick),
        .sample_strobe(sample_strobe), .bit_end_strobe(bit_end_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_bit(input int c0, input int ratio, input int l1, input int l2, input string req);
        push(0, c0 + ratio * (1 + l1) - 1, req);
        push(1, c0 + ratio * (1 + l1 + l2) - 1, req);
    endtask

    task automatic seen(input int kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, (kind == 0) ? "R4 unexpected sample" : "R4 unexpected bit end", cyc, -1);
        end else begin
            e = exp_q.pop_front();
            chk((e.kind == kind) && (e.at == cyc), e.req, cyc * 2 + kind, e.at * 2 + e.kind);
        end
    endtask

    // monitor: pops the scoreboard as strobes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (tq_tick) tick_cnt++;
            if (sample_strobe) seen(0);
            if (bit_end_strobe) seen(1);
        end
    end

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic write_cfg(input bit sel, input logic [15:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start_run(output int c0);
        ctrl_init = 1'b0;
        c0 = cyc + 1;
    endtask

    task automatic halt_at(input int c, input string req);
        wait_cyc(c);
        ctrl_init = 1'b1;
        @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int tk;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tq_tick && !sample_strobe && !bit_end_strobe, "R1 reset",
            {tq_tick, sample_strobe, bit_end_strobe}, 0);

        // R2 timing: P=1, jump-1=1, T1=3, T2=2 -> 2 clk/quantum, 4+3 quanta
        write_cfg(1'b0, 16'h2341);
        write_cfg(1'b1, 16'h0000);
        tk = tick_cnt;
        repeat (40) @(negedge clk);
        chk(tick_cnt == tk, "R1 halted ticks", tick_cnt - tk, 0);

        // R4 / R3 free run, three bits
        start_run(c0);
        tk = tick_cnt;
        for (int b = 0; b < 3; b++) push_bit(c0 + 16 * b, 2, 4, 3, "R4 bit order");
        halt_at(c0 + 47, "R4 queue drained");
        chk(tick_cnt - tk == 24, "R3 ticks per 3 bits", tick_cnt - tk, 24);

        // R5 ignored writes: cce low while halted, then init low while running
        ctrl_cce = 1'b0;
        write_cfg(1'b0, 16'h0000);
        write_cfg(1'b1, 16'h000F);
        ctrl_cce = 1'b1;
        start_run(c0);
        push_bit(c0, 2, 4, 3, "R5 timing kept");
        push_bit(c0 + 16, 2, 4, 3, "R5 timing kept");
        wait_cyc(c0 + 3);
        write_cfg(1'b0, 16'h0000);
        write_cfg(1'b1, 16'h0003);
        halt_at(c0 + 31, "R5 queue drained");

        // R2 / R3 extension word: prescaler 64 -> 65 clocks, T1=1, T2=0
        write_cfg(1'b0, 16'h0100);
        write_cfg(1'b1, 16'h0001);
        start_run(c0);
        tk = tick_cnt;
        push_bit(c0, 65, 2, 1, "R2 extension field");
        halt_at(c0 + 259, "R3 queue drained");
        chk(tick_cnt - tk == 4, "R3 ticks at ratio 65", tick_cnt - tk, 4);

        // R3 maximum division 1024
        write_cfg(1'b0, 16'h013F);
        write_cfg(1'b1, 16'h000F);
        start_run(c0);
        push_bit(c0, 1024, 2, 1, "R3 divide by 1024");
        halt_at(c0 + 4095, "R3 max queue drained");

        // back to base timing
        write_cfg(1'b0, 16'h2341);
        write_cfg(1'b1, 16'h0000);

        // R6 hard sync while idle: edge acted on in cycle c0+5, bit restarts at c0+6
        bus_idle = 1'b1;
        start_run(c0);
        wait_cyc(c0 + 4);
        rx_line = 1'b0;
        push_bit(c0 + 6, 2, 4, 3, "R6 hard sync");
        push_bit(c0 + 22, 2, 4, 3, "R9 rising edge");
        wait_cyc(c0 + 8);
        rx_line = 1'b1;
        halt_at(c0 + 37, "R6 queue drained");
        bus_idle = 1'b0;

        // R7 late edge at segment-1 quantum 3: extension clamped to 2
        start_run(c0);
        wait_cyc(c0 + 5);
        rx_line = 1'b0;
        push_bit(c0, 2, 6, 3, "R7 clamped lengthen");
        push_bit(c0 + 20, 2, 4, 3, "R7 next bit nominal");
        wait_cyc(c0 + 21);
        rx_line = 1'b1;
        halt_at(c0 + 35, "R7 queue drained");

        // R7 small late edge (+1), R9 second edge in same bit and edge in sync
        start_run(c0);
        wait_cyc(c0 + 1);
        rx_line = 1'b0;
        push_bit(c0, 2, 5, 3, "R7 lengthen by one");
        wait_cyc(c0 + 2);
        rx_line = 1'b1;
        wait_cyc(c0 + 3);
        rx_line = 1'b0;
        wait_cyc(c0 + 14);
        rx_line = 1'b1;
        push_bit(c0 + 18, 2, 4, 3, "R9 edge in sync ignored");
        wait_cyc(c0 + 17);
        rx_line = 1'b0;
        halt_at(c0 + 33, "R9 queue drained");
        rx_line = 1'b1;
        repeat (3) @(negedge clk);

        // R8 early edges in segment 2
        start_run(c0);
        wait_cyc(c0 + 9);
        rx_line = 1'b0;
        push(0, c0 + 9, "R8 sample before early edge");
        push(1, c0 + 11, "R8 shorten by jump width");
        push(0, c0 + 21, "R8 second bit sample");
        push(1, c0 + 25, "R8 floor at current quantum");
        push_bit(c0 + 26, 2, 4, 3, "R8 next bit nominal");
        wait_cyc(c0 + 12);
        rx_line = 1'b1;
        wait_cyc(c0 + 23);
        rx_line = 1'b0;
        halt_at(c0 + 41, "R8 queue drained");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule